// File: doc/BRIEF.md
# SDRAM Single-Write Command Sequencer

This block turns one host write request into the pin-level command stream an SDRAM needs to store a single word. The host gives a bank, a row, a column, one data word and a byte mask. The block opens the row, issues a one-beat write with auto-precharge disabled, closes the bank with an explicit precharge, and then waits until the device can accept a new row activation. It assumes the device's mode register is already set for a burst length of one.

Every minimum spacing is given in picoseconds and turned into a cycle count when the block is elaborated, using the clock period parameter. The sequencer is a state machine with seven states:
- `S_IDLE`: ready for a request.
- `S_ACT`: row activation on the pins.
- `S_WAIT_RCD`: the activate-to-write gap.
- `S_WRITE`: write command and data beat.
- `S_WAIT_PRE`: waits until both write recovery and the minimum row-active time are met.
- `S_PRE`: precharge on the pins.
- `S_WAIT_RC`: waits until both the precharge-to-activate and activate-to-activate gaps are met.

It moves through them as follows:
- A request moves `S_IDLE` to `S_ACT`.
- `S_ACT` or `S_WAIT_RCD` moves to `S_WRITE` as soon as the activate-to-write gap is due, and otherwise to `S_WAIT_RCD`.
- `S_WRITE` or `S_WAIT_PRE` moves to `S_PRE` once both of its gaps are due, and otherwise to `S_WAIT_PRE`.
- `S_PRE` or `S_WAIT_RC` moves back to `S_IDLE` once both of its gaps are due, and otherwise to `S_WAIT_RC`.

Top module: `sdram_single_writer`

## Requirements
- R1: For each accepted request the pins carry exactly one ACTIVE, then one WRITE, then one PRECHARGE, with NOP in every other cycle. Commands are encoded on {cs_n, ras_n, cas_n, we_n} as NOP=0111, ACTIVE=0011, WRITE=0100 and PRECHARGE=0010.
- R2: In the ACTIVE cycle, sd_addr equals the request row and sd_ba equals the request bank.
- R3: In the WRITE cycle:
  - sd_addr[COL_W-1:0] carries the column and every higher address bit, A10 included, is 0. COL_W is 8 for a 16-bit device, 9 for 8-bit and 10 for 4-bit.
  - sd_ba carries the bank.
  - sd_dq_out carries the data word with sd_dq_oe high.
  - sd_dqm equals the request mask.
- R4: WRITE is issued exactly N_RCD cycles after ACTIVE.
- R5: PRECHARGE is issued at the later of WRITE + N_WR and ACTIVE + N_RAS. By default it is single-bank: A10=0, sd_ba is the bank, and the other address bits are 0.
- R6: busy falls at the later of PRECHARGE + N_RP and ACTIVE + N_RC. done is high for exactly that one cycle.
- R7: In every cycle that is not a WRITE, sd_dqm is all ones, sd_dq_oe is 0 and sd_dq_out is 0. sd_cke is always 1.
- R8: A request is accepted only in a cycle with busy low, including the cycle in which done is high, and its ACTIVE appears in the next cycle. Requests presented while busy is high are ignored.
- R9: During and right after reset the pins show NOP, busy and done are 0, sd_dqm is all ones and sd_dq_oe is 0.
- R10: Each gap in cycles is ceil(t_ps / T_CK_PS), with a minimum of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_data | input | DEV_WIDTH | Data word |
| req_mask | input | DQM_W | Byte mask, 1 = masked |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the device is ready again |
| sd_cke | output | 1 | Clock enable, held high |
| sd_cs_n | output | 1 | Chip select |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_addr | output | ROW_W | Address pins |
| sd_ba | output | BANK_W | Bank pins |
| sd_dqm | output | DQM_W | Data mask pins |
| sd_dq_out | output | DEV_WIDTH | Data driven toward the DQ pads |
| sd_dq_oe | output | 1 | Output enable for the DQ pads |

## Verification
Two events can share a cycle: the done pulse that closes one sequence, and the acceptance of the next request. The bench provokes this by holding a new request ready, so that it is driven in the very cycle busy falls. It then judges the outcome by comparing the cycle of the second ACTIVE against the first ACTIVE plus the expected gap. Separately, the bench fixes the row-active time longer than the write-recovery path, so the precharge cycle shows which of those two gaps governs it.

// File: rtl/sdw_pkg.sv
package sdw_pkg;
    typedef enum logic [3:0] {
        CMD_NOP = 4'b0111,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_PRE = 4'b0010
    } sd_cmd_e;

    // R10: round up, never below one cycle
    function automatic int unsigned gap_cycles(input int unsigned t_ps, input int unsigned tck_ps);
        int unsigned c;
        c = (t_ps + tck_ps - 1) / tck_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int unsigned col_width(input int unsigned dev_w);
        return (dev_w >= 16) ? 8 : (dev_w == 8) ? 9 : 10;
    endfunction

    function automatic int unsigned mask_width(input int unsigned dev_w);
        return (dev_w >= 16) ? 2 : 1;
    endfunction
endpackage

// File: rtl/sdw_gap_timer.sv
module sdw_gap_timer #(
    parameter int unsigned CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic due_next
);
    localparam int unsigned CW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LOAD_V = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= LOAD_V;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    // high when the gap has elapsed by the next cycle
    assign due_next = load ? (CYCLES <= 1) : (cnt <= CW'(1));
endmodule

// File: rtl/sdw_pin_mux.sv
module sdw_pin_mux
    import sdw_pkg::*;
#(
    parameter int unsigned ROW_W   = 12,
    parameter int unsigned BANK_W  = 2,
    parameter int unsigned COL_W   = 8,
    parameter bit          PRE_ALL = 1'b0
) (
    input  sd_cmd_e           cmd,
    input  logic [BANK_W-1:0] bank,
    input  logic [ROW_W-1:0]  row,
    input  logic [COL_W-1:0]  col,
    output logic [ROW_W-1:0]  addr,
    output logic [BANK_W-1:0] ba
);
    always_comb begin
        addr = '0;
        ba   = '0;
        unique case (cmd)
            CMD_ACT: begin
                addr = row;
                ba   = bank;
            end
            CMD_WR: begin
                addr[COL_W-1:0] = col;
                addr[10]        = 1'b0;
                ba              = bank;
            end
            CMD_PRE: begin
                addr[10] = PRE_ALL;
                ba       = PRE_ALL ? '0 : bank;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sdram_single_writer.sv
module sdram_single_writer
    import sdw_pkg::*;
#(
    parameter int unsigned DEV_WIDTH = 16,
    parameter int unsigned BANK_W    = 2,
    parameter int unsigned ROW_W     = 12,
    parameter int unsigned T_CK_PS   = 7500,
    parameter int unsigned T_RCD_PS  = 15000,
    parameter int unsigned T_RAS_PS  = 37000,
    parameter int unsigned T_RC_PS   = 60000,
    parameter int unsigned T_RP_PS   = 15000,
    parameter int unsigned T_WR_PS   = 15000,
    parameter bit          PRE_ALL   = 1'b0,
    localparam int unsigned COL_W    = col_width(DEV_WIDTH),
    localparam int unsigned DQM_W    = mask_width(DEV_WIDTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [BANK_W-1:0]    req_bank,
    input  logic [ROW_W-1:0]     req_row,
    input  logic [COL_W-1:0]     req_col,
    input  logic [DEV_WIDTH-1:0] req_data,
    input  logic [DQM_W-1:0]     req_mask,
    output logic                 busy,
    output logic                 done,
    output logic                 sd_cke,
    output logic                 sd_cs_n,
    output logic                 sd_ras_n,
    output logic                 sd_cas_n,
    output logic                 sd_we_n,
    output logic [ROW_W-1:0]     sd_addr,
    output logic [BANK_W-1:0]    sd_ba,
    output logic [DQM_W-1:0]     sd_dqm,
    output logic [DEV_WIDTH-1:0] sd_dq_out,
    output logic                 sd_dq_oe
);
    localparam int unsigned N_RCD = gap_cycles(T_RCD_PS, T_CK_PS);
    localparam int unsigned N_RAS = gap_cycles(T_RAS_PS, T_CK_PS);
    localparam int unsigned N_RC  = gap_cycles(T_RC_PS,  T_CK_PS);
    localparam int unsigned N_RP  = gap_cycles(T_RP_PS,  T_CK_PS);
    localparam int unsigned N_WR  = gap_cycles(T_WR_PS,  T_CK_PS);

    localparam int TM_RCD = 0, TM_RAS = 1, TM_RC = 2, TM_WR = 3, TM_RP = 4, TM_COUNT = 5;
    localparam int unsigned GAP_CYC [TM_COUNT] = '{N_RCD, N_RAS, N_RC, N_WR, N_RP};

    typedef enum logic [2:0] {
        S_IDLE, S_ACT, S_WAIT_RCD, S_WRITE, S_WAIT_PRE, S_PRE, S_WAIT_RC
    } seq_state_e;

    seq_state_e state, state_nx;
    sd_cmd_e    cmd;

    logic [BANK_W-1:0]    bank_q;
    logic [ROW_W-1:0]     row_q;
    logic [COL_W-1:0]     col_q;
    logic [DEV_WIDTH-1:0] data_q;
    logic [DQM_W-1:0]     mask_q;
    logic                 done_q;

    logic [TM_COUNT-1:0] gap_load, gap_due;

    // ---------------- gap timers ----------------
    always_comb begin
        gap_load         = '0;
        gap_load[TM_RCD] = (state == S_ACT);
        gap_load[TM_RAS] = (state == S_ACT);
        gap_load[TM_RC]  = (state == S_ACT);
        gap_load[TM_WR]  = (state == S_WRITE);
        gap_load[TM_RP]  = (state == S_PRE);
    end

    for (genvar gi = 0; gi < TM_COUNT; gi++) begin : g_gap
        sdw_gap_timer #(.CYCLES(GAP_CYC[gi])) u_gap (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (gap_load[gi]),
            .due_next (gap_due[gi])
        );
    end

    // ---------------- next state ----------------
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:              if (req_valid) state_nx = S_ACT;
            S_ACT, S_WAIT_RCD:   state_nx = gap_due[TM_RCD] ? S_WRITE : S_WAIT_RCD;
            S_WRITE, S_WAIT_PRE: state_nx = (gap_due[TM_WR] && gap_due[TM_RAS]) ? S_PRE : S_WAIT_PRE;
            S_PRE, S_WAIT_RC:    state_nx = (gap_due[TM_RP] && gap_due[TM_RC]) ? S_IDLE : S_WAIT_RC;
            default:             state_nx = S_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            done_q <= 1'b0;
            bank_q <= '0;
            row_q  <= '0;
            col_q  <= '0;
            data_q <= '0;
            mask_q <= '0;
        end else begin
            state  <= state_nx;
            done_q <= (state != S_IDLE) && (state_nx == S_IDLE);
            if (state == S_IDLE && req_valid) begin
                bank_q <= req_bank;
                row_q  <= req_row;
                col_q  <= req_col;
                data_q <= req_data;
                mask_q <= req_mask;
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        cmd       = CMD_NOP;
        sd_dqm    = '1;
        sd_dq_oe  = 1'b0;
        sd_dq_out = '0;
        unique case (state)
            S_ACT:   cmd = CMD_ACT;
            S_WRITE: begin
                cmd       = CMD_WR;
                sd_dqm    = mask_q;
                sd_dq_oe  = 1'b1;
                sd_dq_out = data_q;
            end
            S_PRE:   cmd = CMD_PRE;
            default: ;
        endcase
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
    assign sd_cke = 1'b1;
    assign busy   = (state != S_IDLE);
    assign done   = done_q;

    sdw_pin_mux #(
        .ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W), .PRE_ALL(PRE_ALL)
    ) u_pins (
        .cmd  (cmd),
        .bank (bank_q),
        .row  (row_q),
        .col  (col_q),
        .addr (sd_addr),
        .ba   (sd_ba)
    );

    // ---------------- assertions ----------------
    localparam int unsigned AGE_W = $clog2(N_RC + N_RAS + N_RP + N_WR + N_RCD + 2) + 1;
    logic [AGE_W-1:0] act_age, wr_age, pre_age;
    sd_cmd_e          pin_cmd, last_cmd;
    assign pin_cmd = sd_cmd_e'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n});

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_age  <= '1;
            wr_age   <= '1;
            pre_age  <= '1;
            last_cmd <= CMD_PRE;
        end else begin
            act_age <= (pin_cmd == CMD_ACT) ? AGE_W'(1) : ((&act_age) ? act_age : act_age + 1'b1);
            wr_age  <= (pin_cmd == CMD_WR)  ? AGE_W'(1) : ((&wr_age)  ? wr_age  : wr_age  + 1'b1);
            pre_age <= (pin_cmd == CMD_PRE) ? AGE_W'(1) : ((&pre_age) ? pre_age : pre_age + 1'b1);
            if (pin_cmd != CMD_NOP) last_cmd <= pin_cmd;
        end
    end

    // R1
    cmd_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_cmd == CMD_WR) |-> last_cmd == CMD_ACT) and
        ((pin_cmd == CMD_PRE) |-> last_cmd == CMD_WR) and
        ((pin_cmd == CMD_ACT) |-> last_cmd == CMD_PRE));
    // R4
    rcd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_cmd == CMD_WR) |-> act_age >= AGE_W'(N_RCD));
    // R5
    pre_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_cmd == CMD_PRE) |-> (act_age >= AGE_W'(N_RAS)) && (wr_age >= AGE_W'(N_WR)));
    // R6
    act_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_cmd == CMD_ACT) |-> (act_age >= AGE_W'(N_RC)) && (pre_age >= AGE_W'(N_RP)));
    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && $past(busy) ##1 !done);
    // R7
    dqm_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_cmd != CMD_WR) |-> (&sd_dqm) && !sd_dq_oe && sd_cke);
    // R8
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> pin_cmd == CMD_ACT);
endmodule

// File: tb/tb_sdram_single_writer.sv
module tb_sdram_single_writer;
    localparam int DEVW = 8;
    localparam int COLW = 9;
    localparam int TCK  = 10000;
    localparam int TRCD = 15000, TRAS = 45000, TRC = 60000, TRP = 15000, TWR = 15000;

    function automatic int ceil_c(input int t);
        int c;
        c = (t + TCK - 1) / TCK;
        return (c < 1) ? 1 : c;
    endfunction

    localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_WR = 4'b0100, C_PRE = 4'b0010;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_bank = '0;
    logic [11:0] req_row = '0;
    logic [COLW-1:0] req_col = '0;
    logic [DEVW-1:0] req_data = '0;
    logic [0:0] req_mask = '0;
    logic busy, done, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
    logic [11:0] sd_addr;
    logic [1:0] sd_ba;
    logic [0:0] sd_dqm;
    logic [DEVW-1:0] sd_dq_out;

    sdram_single_writer #(
        .DEV_WIDTH(DEVW), .T_CK_PS(TCK), .T_RCD_PS(TRCD), .T_RAS_PS(TRAS),
        .T_RC_PS(TRC), .T_RP_PS(TRP), .T_WR_PS(TWR)
    ) dut (
        .clk, .rst_n, .req_valid, .req_bank, .req_row, .req_col, .req_data, .req_mask,
        .busy, .done, .sd_cke, .sd_cs_n, .sd_ras_n, .sd_cas_n, .sd_we_n,
        .sd_addr, .sd_ba, .sd_dqm, .sd_dq_out, .sd_dq_oe
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc++;

    int n_chk = 0, n_err = 0;
    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    typedef struct {
        int         at;
        bit         is_done;
        logic [3:0] cmd;
        logic [11:0] addr;
        logic [1:0] ba;
        logic [DEVW-1:0] dq;
        logic       dqm;
    } item_t;
    item_t exp_q[$];

    // driver: waits for busy low, drives one request, queues expected pin events
    task automatic issue(input logic [1:0] b, input logic [11:0] r, input logic [COLW-1:0] c,
                         input logic [DEVW-1:0] d, input logic m);
        item_t it;
        int a, w, p, dn;
        @(negedge clk);
        while (busy) @(negedge clk);
        req_valid = 1'b1; req_bank = b; req_row = r; req_col = c; req_data = d; req_mask = m;
        a  = cyc + 1;
        w  = a + ceil_c(TRCD);
        p  = (w + ceil_c(TWR) > a + ceil_c(TRAS)) ? w + ceil_c(TWR) : a + ceil_c(TRAS);
        dn = (p + ceil_c(TRP) > a + ceil_c(TRC)) ? p + ceil_c(TRP) : a + ceil_c(TRC);
        it = '{at: a, is_done: 1'b0, cmd: C_ACT, addr: r, ba: b, dq: '0, dqm: 1'b1};
        exp_q.push_back(it);
        it = '{at: w, is_done: 1'b0, cmd: C_WR, addr: {3'b000, c}, ba: b, dq: d, dqm: m};
        exp_q.push_back(it);
        it = '{at: p, is_done: 1'b0, cmd: C_PRE, addr: 12'h000, ba: b, dq: '0, dqm: 1'b1};
        exp_q.push_back(it);
        it = '{at: dn, is_done: 1'b1, cmd: C_NOP, addr: '0, ba: '0, dq: '0, dqm: 1'b1};
        exp_q.push_back(it);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // monitor: compares pin events to queued expectations
    always @(negedge clk) begin
        logic [3:0] pc;
        item_t it;
        pc = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        if (rst_n) begin
            if (pc != C_WR)
                chk(sd_dqm == 1'b1 && !sd_dq_oe && sd_dq_out == '0 && sd_cke, "R7",
                    "idle dqm/oe/dq/cke", {sd_dqm, sd_dq_oe, sd_cke}, 3'b101);
            if (done) begin
                if (exp_q.size() == 0) chk(1'b0, "R6", "unexpected done", 1, 0);
                else begin
                    it = exp_q.pop_front();
                    chk(it.is_done, "R6", "done where command expected", 1, 0);
                    chk(it.at == cyc, "R6", "done cycle", cyc, it.at);
                    chk(!busy, "R6", "busy low with done", busy, 0);
                end
            end
            if (pc != C_NOP) begin
                if (exp_q.size() == 0) chk(1'b0, "R8", "unexpected command", pc, C_NOP);
                else begin
                    it = exp_q.pop_front();
                    chk(!it.is_done && pc == it.cmd, "R1", "command order", pc, it.cmd);
                    chk(it.at == cyc, (pc == C_WR) ? "R4" : (pc == C_PRE) ? "R5" : "R8",
                        "command cycle (R10 gaps)", cyc, it.at);
                    chk(sd_addr == it.addr && sd_ba == it.ba,
                        (pc == C_ACT) ? "R2" : (pc == C_WR) ? "R3" : "R5",
                        "addr/bank", {sd_ba, sd_addr}, {it.ba, it.addr});
                    if (pc == C_WR)
                        chk(sd_dq_oe && sd_dq_out == it.dq && sd_dqm == it.dqm, "R3",
                            "write data/mask", {sd_dq_oe, sd_dqm, sd_dq_out}, {1'b1, it.dqm, it.dq});
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", "run hung", cyc, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP && !busy && !done && sd_dqm == 1'b1 && !sd_dq_oe,
            "R9", "reset outputs", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, busy, done}, {C_NOP, 2'b00});
        rst_n = 1'b1;
        @(negedge clk);
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP && !busy, "R9", "after reset",
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, busy}, {C_NOP, 1'b0});

        // first request, all column bits set, then requests while busy (R8)
        issue(2'd2, 12'hABC, 9'h1FF, 8'hA5, 1'b0);
        req_valid = 1'b1; req_bank = 2'd0; req_row = 12'h123; req_col = 9'h055; req_data = 8'h11;
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
        // R8: spurious requests left no trace
        chk(!busy && {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R8", "busy-time request ignored",
            {busy, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, {1'b0, C_NOP});

        // back-to-back: second request driven in the done cycle (R8, R6)
        issue(2'd1, 12'h001, 9'h155, 8'h3C, 1'b1);
        issue(2'd3, 12'hFFF, 9'h000, 8'hFF, 1'b0);
        issue(2'd0, 12'h800, 9'h100, 8'h00, 1'b1);
        while (busy) @(negedge clk);
        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R1", "all expected events seen", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule